// File: doc/BRIEF.md
# Contiguous Memory Bank Power Enable Controller

This block holds the enable pattern for eight on-chip memory banks and drives one power/enable line per bank. Software writes a requested pattern through a one-cycle register write strobe. The block fills every bit below the highest set bit of that request, so the stored pattern is always a contiguous run of ones starting at bank 0. Bank 0 can never be switched off.

Each accepted write that changes the pattern clears a ready flag. The flag stays low while the affected banks change power state. It returns to 1 once every bank whose enable changed reports, through its power-good input, that it has reached the new state. Writes that arrive while the flag is low are dropped. A read returns the stored pattern in the low bits and the ready flag in a separate status bit. All other read bits are zero.

Top module: `bank_power_ctl`

## Requirements
- R1: After a synchronous active-high reset, all eight bank enables are 1 and the ready flag is 1.
- R2: An accepted write stores ones in every bit from bit 0 up to the highest set bit of write data bits [7:0], and zeros above it. For example, 8'b0001_0111 is stored as 8'b0001_1111.
- R3: Bit 0 of the stored pattern is always 1, so a write of all zeros stores 8'b0000_0001.
- R4: The `bank_en` output equals the stored pattern and is always a contiguous run of ones from bit 0.
- R5: A write presented while the ready flag is 0 is discarded, and the stored pattern keeps its old value.
- R6: An accepted write whose filled pattern differs from the stored one updates `bank_en` and clears the ready flag on the same clock edge.
- R7: While the ready flag is 0, it returns to 1 on the first clock edge at which `bank_pgood` equals `bank_en` in every bit that the last accepted write changed. It never returns to 1 before that edge.
- R8: An accepted write whose filled pattern equals the stored pattern keeps the ready flag at 1 and leaves `bank_en` unchanged.
- R9: The read value has the stored pattern in bits [7:0] and the ready flag in bit 16, with every other bit 0. Write data bits above bit 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 32 | Requested enable pattern in bits [7:0] |
| bank_pgood | input | 8 | Per-bank power-good indication from the power switches |
| rd_data | output | 32 | Read-back: enables [7:0], ready flag in bit 16 |
| bank_en | output | 8 | Per-bank enable; 0 holds the bank powered down |
| mem_ready | output | 1 | Ready flag; 1 when no power transition is pending |

## Verification
The hardest condition to reach from the ports is a write that lands inside the settle window, while some changed banks have reached their new power state and others have not. A dropped write there is invisible until ready returns. The bench's power-good model gives each bank its own random settle delay of zero to several cycles. The random stimulus issues writes on about a third of all cycles, so many of them fall inside partly settled windows. Directed writes then confirm that the pattern seen after ready returns is the one from before the window.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    // Power-transition tracker state.
    typedef enum logic [0:0] {
        BPC_IDLE   = 1'b0,
        BPC_SETTLE = 1'b1
    } bpc_state_e;

    localparam int unsigned BPC_DEF_BANKS  = 8;
    localparam int unsigned BPC_DEF_DATA_W = 32;
    localparam int unsigned BPC_DEF_RDY_AT = 16;

endpackage

// File: rtl/bank_thermo_fill.sv
module bank_thermo_fill #(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic [NUM_BANKS-1:0] raw_i,
    output logic [NUM_BANKS-1:0] fill_o
);

    // Bit i is set when any request bit at or above i is set; bank 0 forced on.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_fill
            if (gi == 0) begin : g_base
                assign fill_o[gi] = 1'b1;
            end else begin : g_upper
                assign fill_o[gi] = |raw_i[NUM_BANKS-1:gi];
            end
        end
    endgenerate

    always_comb begin
        AST_FILL_CONTIG: assert (((fill_o + 1'b1) & fill_o) == '0); // R2
        AST_FILL_BASE:   assert (fill_o[0] == 1'b1);                // R3
    end

endmodule

// File: rtl/bank_settle_track.sv
module bank_settle_track
    import bpc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [NUM_BANKS-1:0] flip_mask_i,
    input  logic [NUM_BANKS-1:0] target_i,
    input  logic [NUM_BANKS-1:0] pgood_i,
    output logic                 ready_o
);

    typedef struct packed {
        bpc_state_e           state;
        logic [NUM_BANKS-1:0] mask;
    } trk_t;

    trk_t trk_d, trk_q;
    logic settled;

    // Only the banks that moved in the last change must report the new state.
    assign settled = ((pgood_i & trk_q.mask) == (target_i & trk_q.mask));

    always_comb begin
        trk_d = trk_q;
        unique case (trk_q.state)
            BPC_IDLE: begin
                if (start_i) begin
                    trk_d.state = BPC_SETTLE;
                    trk_d.mask  = flip_mask_i;
                end
            end
            BPC_SETTLE: begin
                if (settled) begin
                    trk_d.state = BPC_IDLE;
                    trk_d.mask  = '0;
                end
            end
            default: trk_d = trk_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q.state <= BPC_IDLE;
            trk_q.mask  <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign ready_o = (trk_q.state == BPC_IDLE);

    AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !settled) |=> !ready_o); // R7
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && settled) |=> ready_o); // R7
    AST_START_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> !ready_o); // R6

endmodule

// File: rtl/bank_power_ctl.sv
module bank_power_ctl
    import bpc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = BPC_DEF_BANKS,
    parameter int unsigned DATA_W    = BPC_DEF_DATA_W,
    parameter int unsigned RDY_AT    = BPC_DEF_RDY_AT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_BANKS-1:0] bank_pgood,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic              mem_ready
);

    localparam logic [NUM_BANKS-1:0] ALL_ON = {NUM_BANKS{1'b1}};

    typedef struct packed {
        logic [NUM_BANKS-1:0] en;
    } reg_t;

    reg_t reg_d, reg_q;
    logic [NUM_BANKS-1:0] filled;
    logic                 accept;
    logic                 change;
    logic                 ready;
    logic                 unused_hi_bits;

    assign unused_hi_bits = ^wr_data[DATA_W-1:NUM_BANKS];

    bank_thermo_fill #(.NUM_BANKS(NUM_BANKS)) u_fill (
        .raw_i  (wr_data[NUM_BANKS-1:0]),
        .fill_o (filled)
    );

    always_comb begin
        reg_d  = reg_q;
        accept = wr_en && ready;
        change = accept && (filled != reg_q.en);
        if (change) begin
            reg_d.en = filled;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q.en <= ALL_ON;
        end else begin
            reg_q <= reg_d;
        end
    end

    bank_settle_track #(.NUM_BANKS(NUM_BANKS)) u_track (
        .clk         (clk),
        .rst         (rst),
        .start_i     (change),
        .flip_mask_i (filled ^ reg_q.en),
        .target_i    (reg_q.en),
        .pgood_i     (bank_pgood),
        .ready_o     (ready)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[NUM_BANKS-1:0]   = reg_q.en;
        rd_data[RDY_AT]          = ready;
    end

    assign bank_en   = reg_q.en;
    assign mem_ready = ready;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_en == ALL_ON) && mem_ready); // R1
    AST_BANK0_ON: assert property (@(posedge clk) disable iff (rst)
        bank_en[0]); // R3
    AST_EN_CONTIG: assert property (@(posedge clk) disable iff (rst)
        ((bank_en + 1'b1) & bank_en) == '0); // R4
    AST_DROP_BUSY: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |=> $stable(bank_en)); // R5
    AST_TAKE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mem_ready) |=> (bank_en == $past(filled))); // R2
    AST_SAME_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mem_ready && (filled == bank_en)) |=> mem_ready && $stable(bank_en)); // R8
    AST_RD_STATUS: assert property (@(posedge clk) disable iff (rst)
        rd_data[RDY_AT] == mem_ready); // R9

endmodule

// File: tb/sim_bank_power_ctl.sv
module sim_bank_power_ctl;

    localparam int NB = 8;
    localparam int DW = 32;
    localparam int RP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] bank_pgood = '1;
    logic [DW-1:0] rd_data;
    logic [NB-1:0] bank_en;
    logic          mem_ready;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    bank_power_ctl #(.NUM_BANKS(NB), .DATA_W(DW), .RDY_AT(RP)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bank_pgood(bank_pgood), .rd_data(rd_data), .bank_en(bank_en),
        .mem_ready(mem_ready)
    );

    always #10 clk = ~clk;

    // Reference model state.
    logic [NB-1:0] e_en  = '1;
    logic          e_rdy = 1'b1;
    logic [NB-1:0] e_chg = '0;

    function automatic logic [NB-1:0] fill_ref(input logic [DW-1:0] d);
        logic [NB-1:0] r;
        int top;
        top = 0;
        for (int i = 0; i < NB; i++) if (d[i]) top = i;
        r = '0;
        for (int i = 0; i < NB; i++) r[i] = (i <= top);
        return r;
    endfunction

    function automatic logic [DW-1:0] rd_ref(input logic [NB-1:0] en, input logic rdy);
        logic [DW-1:0] r;
        r = '0;
        r[NB-1:0] = en;
        r[RP] = rdy;
        return r;
    endfunction

    always @(posedge clk) begin
        logic [NB-1:0] f;
        f = fill_ref(wr_data);
        if (rst) begin
            e_en = '1; e_rdy = 1'b1; e_chg = '0;
        end else if (e_rdy) begin
            if (wr_en && f != e_en) begin
                e_chg = f ^ e_en; e_en = f; e_rdy = 1'b0;
            end
        end else if ((bank_pgood & e_chg) == (e_en & e_chg)) begin
            e_rdy = 1'b1; e_chg = '0;
        end
    end

    // Power-good model: each bank follows its enable after a random delay.
    int unsigned pcnt [NB];
    int unsigned pdly [NB];
    initial for (int i = 0; i < NB; i++) begin pcnt[i] = 0; pdly[i] = 0; end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R4 bank_en", {{(DW-NB){1'b0}}, bank_en}, {{(DW-NB){1'b0}}, e_en});
            chk("R7 ready", {{(DW-1){1'b0}}, mem_ready}, {{(DW-1){1'b0}}, e_rdy});
            chk("R9 readback", rd_data, rd_ref(e_en, e_rdy));
        end
        for (int i = 0; i < NB; i++) begin
            if (bank_pgood[i] != bank_en[i]) begin
                if (pcnt[i] == 0) pdly[i] = $urandom_range(0, 5);
                if (pcnt[i] >= pdly[i]) begin
                    bank_pgood[i] <= bank_en[i];
                    pcnt[i] = 0;
                end else pcnt[i]++;
            end else pcnt[i] = 0;
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rdy();
        for (int k = 0; k < 100; k++) begin
            if (mem_ready) break;
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset enables", {{(DW-NB){1'b0}}, bank_en}, 32'h0000_00ff);
        chk("R1 reset ready", {31'b0, mem_ready}, 32'h1);

        put(32'h0000_0017);
        #1;
        chk("R2 fill 17->1f", {{(DW-NB){1'b0}}, bank_en}, 32'h0000_001f);
        chk("R6 ready low", {31'b0, mem_ready}, 32'h0);
        // Write while settling must be dropped.
        wr_en = 1'b1; wr_data = 32'h0000_00ff;
        @(negedge clk);
        wr_en = 1'b0;
        wait_rdy();
        chk("R5 dropped write", {{(DW-NB){1'b0}}, bank_en}, 32'h0000_001f);

        put(32'h0000_0000);
        #1;
        chk("R3 zero write", {{(DW-NB){1'b0}}, bank_en}, 32'h0000_0001);
        wait_rdy();

        put(32'h0000_0001);
        #1;
        chk("R8 same pattern ready", {31'b0, mem_ready}, 32'h1);
        chk("R8 same pattern en", {{(DW-NB){1'b0}}, bank_en}, 32'h0000_0001);

        put(32'hffff_ff80);
        #1;
        chk("R9 upper bits ignored", rd_data, 32'h0000_00ff);
        wait_rdy();
        chk("R9 readback ready", rd_data, 32'h0001_00ff);

        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_data = $urandom();
            if ($urandom_range(0, 3) == 0) wr_data[NB-1:0] = wr_data[NB-1:0] & 8'h0f;
            if (n == 1500) rst = 1'b1;
            if (n == 1502) rst = 1'b0;
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule